// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a two-wire serial bus whose clock and data lines have already been synchronized to the system clock. After a start condition it shifts in the first byte of the transfer. That byte carries a seven-bit address, sent most significant bit first, and then a direction bit. The block compares the address with a programmable own-address input. On a match it raises a selected flag, latches the direction, pulls the data line low for the acknowledge slot and issues a one-cycle interrupt.

The block also recognizes the reserved extension-code group of first bytes. These set their own flag and raise the interrupt, but they do not select the slave. If the first byte is neither the local address nor an extension code, the block stays silent. Selection lasts until the next start condition, repeated or not, or until a stop condition. Clock and data enter as plain levels. The open-drain enable leaves as a plain level, and the surrounding pad logic turns it into a pull-down on the data line. There is no streaming data path.

Top module: `i2c_addr_match`

## Requirements
- R1: A start condition (data falling while clock is high) opens an address phase. The data line is sampled on each of the next 8 clock rising edges, MSB first. The result is shown on `first_byte_o`, with the address in bits 7:1 and the direction bit in bit 0. Later clock edges, up to the next start, leave `first_byte_o` unchanged.
- R2: If bits 7:1 of the first byte equal `own_addr`, then `sel_o` is 1 after the falling edge of the ninth clock. `dir_o` then holds bit 0 of the byte: 0 means the master writes, 1 means the master reads.
- R3: On a local-address match, `sda_oe_o` is 1 from the eighth clock falling edge until the ninth clock falling edge, which covers the whole ninth high period. On a mismatch it is never 1, and it is 0 during all eight address bits.
- R4: `irq_o` is a pulse exactly one system clock wide. It is issued once per address phase, right after the ninth clock falls, and only when the byte is the local address or an extension code.
- R5: A first byte whose bits 7:3 are 11110 sets `ext_o`. It sets `sel_o` only if it also matches `own_addr`.
- R6: A stop condition (data rising while clock is high) clears `sel_o`, `ext_o` and `dir_o`.
- R7: A repeated start clears `sel_o`, `ext_o` and `dir_o` before the new address is received.
- R8: Synchronous active-high `rst` clears `first_byte_o`, `sel_o`, `ext_o`, `dir_o`, `irq_o` and `sda_oe_o`.
- R9: A first byte that is neither the local address nor an extension code gives no interrupt, no flags and no acknowledge. It is still shown on `first_byte_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| own_addr | input | 7 | Programmable own slave address |
| first_byte_o | output | 8 | Last received first byte (address in 7:1, direction in 0) |
| sel_o | output | 1 | Slave selected |
| ext_o | output | 1 | Extension-code first byte received |
| dir_o | output | 1 | Latched direction (1 = master reads) |
| irq_o | output | 1 | One-cycle address-phase interrupt |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the acknowledge |

## Verification
The embedded assertions check several rules on every cycle: the interrupt lasts one clock and appears only alongside a raised flag; start and stop clear the flags; a rising flag agrees with the captured byte; the bit counter never passes eight; and the acknowledge is released only by a clock fall or a bus condition. Only the bench's scenarios can show the rest: that the bits land MSB first, that a mismatch stays fully silent, that the acknowledge spans the ninth high period, and that clocks after the address phase and repeated starts behave as required.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = ADDR_W + 1;
  localparam int EXT_W    = 5;
  localparam logic [EXT_W-1:0] EXT_TAG = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  // bus conditions need the clock high on both samples
  assign start_o = scl & scl_q & sda_q & ~sda;
  assign stop_o  = scl & scl_q & ~sda_q & sda;
  assign rise_o  = scl & ~scl_q;
  assign fall_o  = ~scl & scl_q;
endmodule

// File: rtl/i2c_addr_shifter.sv
module i2c_addr_shifter
  import i2c_rec_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            rise_i,
  input  logic            fall_i,
  output logic [BITS-1:0] byte_o,
  output logic            ack_win_o,
  output logic            ack_done_o
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (start_i) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      shreg <= '0;
    end else if (stop_i) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          if (rise_i && cnt < LAST) begin
            shreg <= {shreg[BITS-2:0], sda};
            cnt   <= cnt + 1'b1;
          end
          if (fall_i && cnt == LAST) phase <= PH_ACK;
        end
        PH_ACK: if (fall_i) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign byte_o     = shreg;
  assign ack_win_o  = (phase == PH_ACK);
  assign ack_done_o = (phase == PH_ACK) & fall_i;

  // R1
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_rec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [BYTE_W-1:0] first_byte_o,
  output logic              sel_o,
  output logic              ext_o,
  output logic              dir_o,
  output logic              irq_o,
  output logic              sda_oe_o
);
  logic ev_start, ev_stop, ev_rise, ev_fall;
  logic ack_win, ack_done;
  logic local_hit, ext_hit;
  logic sel_q, ext_q, dir_q, irq_q;

  i2c_line_events u_events (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda),
    .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall)
  );

  i2c_addr_shifter #(.BITS(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .sda(sda),
    .start_i(ev_start), .stop_i(ev_stop), .rise_i(ev_rise), .fall_i(ev_fall),
    .byte_o(first_byte_o), .ack_win_o(ack_win), .ack_done_o(ack_done)
  );

  assign local_hit = (first_byte_o[BYTE_W-1:1] == own_addr);
  assign ext_hit   = (first_byte_o[BYTE_W-1 -: EXT_W] == EXT_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      ext_q <= 1'b0;
      dir_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ack_done & (local_hit | ext_hit);
      if (ev_start || ev_stop) begin
        sel_q <= 1'b0;
        ext_q <= 1'b0;
        dir_q <= 1'b0;
      end else if (ack_done) begin
        sel_q <= local_hit;
        ext_q <= ext_hit;
        dir_q <= local_hit & first_byte_o[0];
      end
    end
  end

  assign sel_o    = sel_q;
  assign ext_o    = ext_q;
  assign dir_o    = dir_q;
  assign irq_o    = irq_q;
  assign sda_oe_o = ack_win & local_hit;

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (sel_o || ext_o));
  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!sel_o && !ext_o && !dir_o));
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> (!sel_o && !ext_o && !dir_o));
  // R2
  sel_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_o) |-> (first_byte_o[BYTE_W-1:1] == $past(own_addr)));
  // R5
  ext_tag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_o) |-> (first_byte_o[BYTE_W-1 -: EXT_W] == EXT_TAG));
  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe_o) && !$past(ev_start || ev_stop)) |-> $past(ev_fall));
endmodule

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic clk = 1'b0;
  logic rst;
  logic scl, m_sda;
  logic [6:0] own_addr;
  logic [7:0] first_byte_o;
  logic sel_o, ext_o, dir_o, irq_o, sda_oe_o;
  wire bus_sda = m_sda & ~sda_oe_o;

  int checks = 0, failures = 0;
  int irq_cnt = 0;
  logic irq_prev = 1'b0;
  logic irq_wide = 1'b0;
  logic ack_seen, oe_early;

  always #10 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst(rst), .scl(scl), .sda(bus_sda), .own_addr(own_addr),
    .first_byte_o(first_byte_o), .sel_o(sel_o), .ext_o(ext_o), .dir_o(dir_o),
    .irq_o(irq_o), .sda_oe_o(sda_oe_o)
  );

  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (irq_o && irq_prev) irq_wide = 1'b1;
    irq_prev = irq_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(2); scl = 1'b1; tick(4);
    m_sda = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(4); scl = 1'b1; tick(4);
    m_sda = 1'b1; tick(4);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(4);
    scl = 1'b1; tick(2);
    if (sda_oe_o) oe_early = 1'b1;
    tick(2);
    scl = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    oe_early = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    // ninth clock: master releases data, watch the acknowledge
    m_sda = 1'b1; tick(2);
    ack_seen = sda_oe_o;
    tick(2); scl = 1'b1; tick(2);
    ack_seen = ack_seen & sda_oe_o & ~bus_sda;
    tick(2); scl = 1'b0; tick(4);
  endtask

  // {own[18:12], byte[11:4], sel, ext, irq, ack}
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {7'h2A, 8'h54, 4'b1011},
    {7'h2A, 8'h55, 4'b1011},
    {7'h2A, 8'h56, 4'b0000},
    {7'h2A, 8'hF2, 4'b0110},
    {7'h7F, 8'hFF, 4'b1011},
    {7'h00, 8'h01, 4'b1011},
    {7'h78, 8'hF1, 4'b1111}
  };

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; scl = 1'b1; m_sda = 1'b1; own_addr = 7'h2A;
    tick(4);
    // R8 reset state
    check("R8 reset", {first_byte_o, sel_o, ext_o, dir_o, irq_o, sda_oe_o}, 13'h0);
    rst = 1'b0; tick(4);

    for (int v = 0; v < NV; v++) begin
      int base;
      logic [7:0] b;
      b = VEC[v][11:4];
      own_addr = VEC[v][18:12];
      base = irq_cnt;
      bus_start();
      send_byte(b);
      tick(2);
      check("R1 captured byte", first_byte_o, b);
      check("R2 sel", sel_o, VEC[v][3]);
      check("R2 dir", dir_o, VEC[v][3] & b[0]);
      check("R5 ext", ext_o, VEC[v][2]);
      check("R4 R9 irq count", irq_cnt - base, VEC[v][1]);
      check("R3 ack slot", ack_seen, VEC[v][0]);
      check("R3 no drive during address bits", oe_early, 1'b0);
      bus_stop();
      tick(2);
      check("R6 stop clears", {sel_o, ext_o, dir_o}, 3'b000);
    end

    // R10-style: clocks after the address phase change nothing (R1, R4)
    own_addr = 7'h2A;
    bus_start();
    send_byte(8'h55);
    begin
      int base;
      base = irq_cnt;
      send_byte(8'hA3);
      tick(2);
      check("R1 later clocks ignored", first_byte_o, 8'h55);
      check("R4 no irq in data phase", irq_cnt - base, 0);
      check("R3 no ack in data phase", ack_seen, 1'b0);
      check("R2 selection persists", {sel_o, dir_o}, 2'b11);
    end

    // R7 repeated start drops selection
    m_sda = 1'b1; tick(4); scl = 1'b1; tick(4);
    m_sda = 1'b0; tick(2);
    check("R7 repeated start clears", {sel_o, ext_o, dir_o}, 3'b000);
    tick(2); scl = 1'b0; tick(4);
    send_byte(8'hF4);
    tick(2);
    check("R5 ext after repeated start", {sel_o, ext_o}, 2'b01);

    // R8 reset while selected
    bus_stop(); bus_start(); send_byte(8'h54);
    tick(2);
    check("R2 selected before reset", sel_o, 1'b1);
    rst = 1'b1; tick(2);
    check("R8 reset clears", {first_byte_o, sel_o, ext_o, dir_o, irq_o, sda_oe_o}, 13'h0);
    rst = 1'b0; tick(2);

    check("R4 pulse width", irq_wide, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule